// File: doc/BRIEF.md
# Reloading Periodic Down-Counter with Interrupt

This block is a periodic timer for a processor subsystem. A down-counter advances once per base tick (the `tick_en` strobe, nominally 100 MHz). When it runs out, it reloads itself from a programmable period register and raises a pending interrupt. A divider of 1,000,000 therefore gives a 100 Hz event rate.

Software drives the block through a small word-wide register port. The bring-up sequence is:
1. Program the period.
2. Issue a load command, which copies the period into the counter.
3. Issue a run command.

Reading the live counter gives the time elapsed within the current period: the period value minus the value read. A read taken just after a wrap returns a larger value than the read taken just before it.

The interrupt path keeps four functions separate:
- a raw pending latch;
- a mask bit;
- a masked-status view;
- a write-one-to-clear acknowledge.

The system interrupt line is a registered copy of the masked pending state.

Top module: `periodic_tick_timer`

## Requirements
- R1: After synchronous reset the counter, period, mask and raw pending bit are 0, the timer is stopped, `irq_o` is 0 and `bus_rdata` is 0.
- R2: Writing the command register (address 1) with bits[1:0]=01 (load) copies the period register (address 0, read/write) into the counter. Writing the period alone never changes the counter.
- R3: While running, the counter decrements by 1 on each cycle with `tick_en`=1. It holds on cycles with `tick_en`=0. It is readable at address 2.
- R4: A running counter that ticks at a value of 1 or 0 reloads from the period register instead of decrementing. A period of N therefore gives a wrap every N ticks.
- R5: Command bits[1:0]=11 (stop) freezes the counter at its current value without reload. Command 10 (run) resumes counting from that value.
- R6: Writing the period while the timer runs has no effect on the counter until the next wrap or load.
- R7: The raw pending bit (address 6, bit 0) sets on the tick that wraps. It stays set until acknowledged.
- R8: Writing address 5 with bit 0 = 1 clears the raw pending bit, and bit 0 = 0 leaves it alone. A wrap in the same cycle as the acknowledge leaves the bit set.
- R9: The mask (address 3, bit 0) is read/write. The masked status at address 4, bit 0 reads raw AND mask.
- R10: `irq_o` equals raw pending AND mask. It changes on the same clock edge as those bits.
- R11: Reads return the addressed value on `bus_rdata` one clock after the address is presented. The command (1), acknowledge (5) and unused (7) addresses read 0. Command 00 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base-rate tick strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A counter wrap and a software acknowledge can land in the same cycle. When they do, the latch must favour the new event.

The bench provokes this by running the counter down to 1 and then issuing the acknowledge write with `tick_en` held high in that same cycle. It judges the result through the raw pending readback, which must stay 1, and through the counter, which must read the reloaded period. A plain acknowledge afterwards must then clear the bit.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LOAD = 2'b01,
    OP_RUN  = 2'b10,
    OP_STOP = 2'b11
  } op_e;

  localparam logic [ADDR_W-1:0] A_DIV   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACK   = 3'd5;
  localparam logic [ADDR_W-1:0] A_RAW   = 3'd6;
endpackage

// File: rtl/ptt_regif.sv
module ptt_regif
  import ptt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              raw,
  input  logic              mask,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  div,
  output logic              load_p,
  output logic              run_p,
  output logic              stop_p,
  output logic              mask_wr,
  output logic              mask_bit,
  output logic              ack_p
);
  logic [CNT_W-1:0]  div_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_n;
  logic              ctrl_wr;
  op_e               op;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign op       = op_e'(bus_wdata[1:0]);
  assign load_p   = ctrl_wr && (op == OP_LOAD);
  assign run_p    = ctrl_wr && (op == OP_RUN);
  assign stop_p   = ctrl_wr && (op == OP_STOP);
  assign mask_wr  = bus_wr && (bus_addr == A_MASK);
  assign mask_bit = bus_wdata[0];
  assign ack_p    = bus_wr && (bus_addr == A_ACK) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (bus_wr && (bus_addr == A_DIV)) begin
      div_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      A_DIV:   rd_n[CNT_W-1:0] = div_q;
      A_COUNT: rd_n[CNT_W-1:0] = count;
      A_MASK:  rd_n[0] = mask;
      A_MSTAT: rd_n[0] = raw & mask;
      A_RAW:   rd_n[0] = raw;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_n;
  end

  assign div   = div_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_p,
  input  logic             run_p,
  input  logic             stop_p,
  input  logic [CNT_W-1:0] div,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             wrap
);
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             step;

  // a command cycle takes precedence over ticking
  assign step = run_q && tick_en && !(load_p || run_p || stop_p);
  assign wrap = step && (count_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (load_p)      count_q <= div;
      else if (wrap)   count_q <= div;
      else if (step)   count_q <= count_q - CNT_W'(1);

      if (stop_p)      run_q <= 1'b0;
      else if (run_p)  run_q <= 1'b1;
    end
  end

  assign count   = count_q;
  assign running = run_q;
endmodule

// File: rtl/ptt_irq.sv
module ptt_irq (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic ack_p,
  input  logic mask_wr,
  input  logic mask_bit,
  output logic raw,
  output logic mask,
  output logic irq
);
  logic raw_q, mask_q, irq_q;
  logic raw_n, mask_n;

  // event wins over acknowledge
  assign raw_n  = wrap | (raw_q & ~ack_p);
  assign mask_n = mask_wr ? mask_bit : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_n;
      mask_q <= mask_n;
      irq_q  <= raw_n & mask_n;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] count_q;
  logic             running_q;
  logic             wrap;
  logic             load_p, run_p, stop_p;
  logic             mask_wr, mask_bit, ack_p;
  logic             raw_q, mask_q;

  ptt_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .count(count_q), .raw(raw_q), .mask(mask_q),
    .rdata(bus_rdata), .div(div_q),
    .load_p(load_p), .run_p(run_p), .stop_p(stop_p),
    .mask_wr(mask_wr), .mask_bit(mask_bit), .ack_p(ack_p)
  );

  ptt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .load_p(load_p), .run_p(run_p), .stop_p(stop_p),
    .div(div_q), .count(count_q), .running(running_q), .wrap(wrap)
  );

  ptt_irq u_irq (
    .clk(clk), .rst(rst), .wrap(wrap), .ack_p(ack_p),
    .mask_wr(mask_wr), .mask_bit(mask_bit),
    .raw(raw_q), .mask(mask_q), .irq(irq_o)
  );
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             irq_o,
  input logic             raw_q,
  input logic             mask_q,
  input logic             wrap,
  input logic             ack_p,
  input logic             load_p,
  input logic             run_p,
  input logic             stop_p,
  input logic             running_q,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] div_q
);
  // R10
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (raw_q & mask_q));

  // R7
  wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> raw_q);

  // R7
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !ack_p) |=> raw_q);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_p && !wrap) |=> !raw_q);

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load_p |=> (count_q == $past(div_q)));

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_q == $past(div_q)));

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (running_q && tick_en && !load_p && !run_p && !stop_p && (count_q > CNT_W'(1)))
      |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_p) |=> $stable(count_q));

  // R5
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !load_p) |=> $stable(count_q));
endmodule

bind periodic_tick_timer ptt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .irq_o(irq_o),
  .raw_q(raw_q), .mask_q(mask_q), .wrap(wrap), .ack_p(ack_p),
  .load_p(load_p), .run_p(run_p), .stop_p(stop_p),
  .running_q(running_q), .count_q(count_q), .div_q(div_q)
);

// File: tb/periodic_tick_timer_test.sv
module periodic_tick_timer_test;
  import ptt_pkg::*;

  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rd_req = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  periodic_tick_timer #(.DATA_W(DW), .CNT_W(DW)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: compares read results against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (rd_req) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, bus_rdata, e);
        end
      end
    end
  end

  // all driver tasks start and end just after a falling edge
  task automatic wrt(input logic [2:0] a, input logic [DW-1:0] d, input logic tk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wrt(a, d, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_COUNT, 0, "R1 count");
    rd(A_RAW,   0, "R1 raw");
    rd(A_MASK,  0, "R1 mask");
    rd(A_DIV,   0, "R1 div");
    check("R1 irq", DW'(irq_o), 0);

    // R2 period write alone, then load
    wr(A_DIV, 10);
    rd(A_DIV,   10, "R2 div readback");
    rd(A_COUNT, 0,  "R2 no load on period write");
    wr(A_CTRL, 32'h1);
    rd(A_COUNT, 10, "R2 load");
    wr(A_CTRL, 32'h0);
    rd(A_COUNT, 10, "R11 no-op command");

    // R3 run and tick
    wr(A_CTRL, 32'h2);
    tick(3);
    rd(A_COUNT, 7, "R3 decrement");
    idle(4);
    rd(A_COUNT, 7, "R3 hold without tick");

    // R6 period change while running
    wr(A_DIV, 4);
    rd(A_COUNT, 7, "R6 period write no effect");
    tick(6);
    rd(A_COUNT, 1, "R6 count before wrap");
    rd(A_RAW,   0, "R7 raw before wrap");
    tick(1);
    rd(A_COUNT, 4, "R4 reload new period");
    rd(A_RAW,   1, "R7 raw set on wrap");
    rd(A_MSTAT, 0, "R9 masked status mask off");
    check("R10 irq masked off", DW'(irq_o), 0);

    // R9 R10 mask on
    wr(A_MASK, 1);
    rd(A_MSTAT, 1, "R9 masked status mask on");
    rd(A_MASK,  1, "R9 mask readback");
    check("R10 irq asserted", DW'(irq_o), 1);
    rd(A_CTRL, 0, "R11 command reads 0");
    rd(A_ACK,  0, "R11 ack reads 0");
    rd(3'd7,   0, "R11 unused reads 0");

    // R8 acknowledge
    wr(A_ACK, 0);
    rd(A_RAW, 1, "R8 ack bit0=0 ignored");
    wr(A_ACK, 1);
    rd(A_RAW, 0, "R8 ack clears");
    check("R10 irq after ack", DW'(irq_o), 0);

    // R5 stop and resume
    wr(A_CTRL, 32'h3);
    tick(5);
    rd(A_COUNT, 4, "R5 frozen");
    rd(A_RAW,   0, "R5 no wrap while stopped");
    wr(A_CTRL, 32'h2);
    tick(2);
    rd(A_COUNT, 2, "R5 resume");

    // R8 wrap and ack in the same cycle
    tick(1);
    rd(A_COUNT, 1, "R8 count at 1");
    wrt(A_ACK, 1, 1'b1);
    rd(A_RAW,   1, "R8 wrap wins over ack");
    rd(A_COUNT, 4, "R4 reload in collision");
    check("R10 irq on collision", DW'(irq_o), 1);

    // R4 exact period
    wr(A_ACK, 1);
    tick(3);
    rd(A_RAW,   0, "R4 no wrap after 3 ticks");
    rd(A_COUNT, 1, "R4 count after 3 ticks");
    tick(1);
    rd(A_RAW,   1, "R4 wrap on 4th tick");
    rd(A_COUNT, 4, "R4 reload on 4th tick");

    // R2 load while running
    wr(A_DIV, 9);
    wr(A_CTRL, 32'h1);
    rd(A_COUNT, 9, "R2 load while running");
    tick(1);
    rd(A_COUNT, 8, "R3 still running after load");

    // R9 R10 mask off with pending
    wr(A_MASK, 0);
    check("R10 irq mask off", DW'(irq_o), 0);
    rd(A_MSTAT, 0, "R9 masked status cleared");
    rd(A_RAW,   1, "R9 raw kept");

    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule